// File: doc/BRIEF.md
# Iterative Early-Terminating Multiplier

This block multiplies two 32-bit unsigned operands for a five-stage in-order integer pipeline and returns the low 32 bits of the product. It is not pipelined: one multiply is in flight at a time. Each busy cycle it takes the next 11 bits of the multiplier operand, forms 11 gated and shifted copies of the multiplicand and adds them into a running sum. A 32-bit multiplier therefore needs at most three passes, and the unit stops as soon as every multiplier bit not yet consumed is zero.

The request side follows valid/ready rules. `start_i` acts as the valid and the inverse of `busy_o` acts as the ready. A request is taken on a rising clock edge where `start_i` is high and `busy_o` is low. A request presented while `busy_o` is high is dropped, not queued, so the issuing stage must hold it until `busy_o` is low. The pipeline control also uses `busy_o` to keep the multiply in Execute and the next instruction in Decode. The result side has no back-pressure. `done_o` pulses for exactly one cycle, and during that cycle `result_o` is the product. `result_o` then keeps that value until the next multiply finishes.

Top module: `emt_mul`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: A request with `start_i` high while `busy_o` is low is accepted on that clock edge, and `busy_o` is high in the next cycle.
- R3: When `done_o` is high, `result_o` equals `mcand_i * mplr_i` as captured at acceptance, both taken as unsigned.
- R4: Product bits at positions 32 and above are discarded: `result_o` is the product modulo 2^32.
- R5: `busy_o` stays high for N consecutive cycles. N is 1 when the multiplier is 0. Otherwise N is ceil(L/11), where L is the index of the highest set bit plus one. N is therefore never more than 3.
- R6: `done_o` is high in exactly the cycle after the last busy cycle, is never high together with `busy_o`, and lasts one cycle.
- R7: `start_i` has no effect while `busy_o` is high. The multiply in progress keeps its operands and timing, and no second operation follows it.
- R8: `result_o` stays constant in every cycle in which `done_o` is low.
- R9: A new request may be accepted in the same cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| start_i | input | 1 | Request valid; accepted when `busy_o` is low |
| mcand_i | input | 32 | Multiplicand, unsigned |
| mplr_i | input | 32 | Multiplier, unsigned; its upper zero bits shorten the operation |
| busy_o | output | 1 | Operation in progress; inverse of request ready; stall for the pipeline |
| done_o | output | 1 | One-cycle pulse marking a valid `result_o` |
| result_o | output | 32 | Low 32 bits of the product |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any request. They also assume that `start_i` and the operands are stable around each rising edge. The bench changes every input only on falling edges and releases reset before the first request. The assertions place no limit on `start_i` during busy cycles, and the bench drives it high there on purpose. The bench also picks multiplier values on both sides of each 11-bit chunk boundary, so that every possible busy length occurs.

// File: rtl/emt_pkg.sv
package emt_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } emt_state_e;

  function automatic int unsigned ceil_div(input int unsigned n, input int unsigned d);
    return (n + d - 1) / d;
  endfunction

endpackage

// File: rtl/emt_ppbank.sv
// One pass of partial-product accumulation: CHUNK gated, shifted copies of
// the (already pre-shifted) multiplicand are added to the running sum.
module emt_ppbank #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CHUNK = 11
) (
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [CHUNK-1:0] chunk_i,
  input  logic [WIDTH-1:0] acc_i,
  output logic [WIDTH-1:0] sum_o
);

  logic [WIDTH-1:0] pp [CHUNK];

  generate
    for (genvar gi = 0; gi < CHUNK; gi++) begin : g_row
      assign pp[gi] = chunk_i[gi] ? (mcand_i << gi) : '0;
    end
  endgenerate

  always_comb begin
    sum_o = acc_i;
    for (int i = 0; i < CHUNK; i++) begin
      sum_o = sum_o + pp[i];
    end
  end

endmodule

// File: rtl/emt_operands.sv
// Operand registers: the multiplicand moves up by one chunk per pass and the
// multiplier moves down, so each pass sees its chunk at bit 0.
module emt_operands #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CHUNK = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplr_i,
  output logic [WIDTH-1:0] mcand_o,
  output logic [CHUNK-1:0] chunk_o,
  output logic             rest_zero_o
);

  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] mplr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand_q <= '0;
      mplr_q  <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
      mplr_q  <= mplr_i;
    end else if (step_i) begin
      mcand_q <= mcand_q << CHUNK;
      mplr_q  <= mplr_q >> CHUNK;
    end
  end

  assign mcand_o     = mcand_q;
  assign chunk_o     = mplr_q[CHUNK-1:0];
  assign rest_zero_o = ((mplr_q >> CHUNK) == '0);

  // R7: with neither load nor step from control, operands stay frozen
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> ($stable(mcand_q) && $stable(mplr_q)));

endmodule

// File: rtl/emt_ctrl.sv
// Handshake and pass sequencing.
module emt_ctrl
  import emt_pkg::*;
#(
  parameter int unsigned NCHUNK = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rest_zero_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CW = $clog2(NCHUNK + 1);

  emt_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign busy_o   = (state_q == ST_RUN);
  assign load_o   = start_i && (state_q == ST_IDLE);
  assign step_o   = busy_o;
  assign finish_o = busy_o && (rest_zero_i || (cnt_q == CW'(NCHUNK - 1)));
  assign done_o   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish_o;
      case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: if (finish_o) state_q <= ST_IDLE;
                else          cnt_q   <= cnt_q + 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q < CW'(NCHUNK)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: rtl/emt_mul.sv
module emt_mul
  import emt_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned CHUNK = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplr_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);

  localparam int unsigned NCHUNK = ceil_div(WIDTH, CHUNK);

  logic             load, step, finish, rest_zero;
  logic [WIDTH-1:0] mcand_sh, sum;
  logic [CHUNK-1:0] chunk;
  logic [WIDTH-1:0] acc_q, result_q;

  emt_ctrl #(.NCHUNK(NCHUNK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rest_zero_i(rest_zero),
    .load_o(load), .step_o(step), .finish_o(finish),
    .busy_o(busy_o), .done_o(done_o)
  );

  emt_operands #(.WIDTH(WIDTH), .CHUNK(CHUNK)) u_ops (
    .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
    .mcand_i(mcand_i), .mplr_i(mplr_i),
    .mcand_o(mcand_sh), .chunk_o(chunk), .rest_zero_o(rest_zero)
  );

  emt_ppbank #(.WIDTH(WIDTH), .CHUNK(CHUNK)) u_bank (
    .mcand_i(mcand_sh), .chunk_i(chunk), .acc_i(acc_q), .sum_o(sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      result_q <= '0;
    end else begin
      if (load)        acc_q <= '0;
      else if (step)   acc_q <= sum;
      if (finish)      result_q <= sum;
    end
  end

  assign result_o = result_q;

  // R8: the result changes only on the edge that raises done
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

endmodule

// File: tb/test_emt_mul.sv
`timescale 1ns/1ps
module test_emt_mul;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] mcand_i = '0;
  logic [31:0] mplr_i = '0;
  logic        busy_o, done_o;
  logic [31:0] result_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  emt_mul i_emt_mul (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mcand_i(mcand_i),
    .mplr_i(mplr_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    p = 64'(a) * 64'(b);
    return p[31:0];
  endfunction

  function automatic int exp_cycles(input logic [31:0] b);
    int len = 0;
    for (int i = 0; i < 32; i++) if (b[i]) len = i + 1;
    return (len == 0) ? 1 : (len + 10) / 11;
  endfunction

  // Presents a request at a falling edge; returns after the accepting edge.
  task automatic issue(input logic [31:0] a, input logic [31:0] b);
    mcand_i = a; mplr_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Counts busy cycles until done, then checks result, length and pulse width.
  task automatic finish_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                           input bit poke_busy);
    int n = 0;
    while (!done_o && n < 10) begin
      if (busy_o) n++;
      if (poke_busy) begin
        mcand_i = 32'hFFFF_FFFF; mplr_i = 32'h1; start_i = 1'b1;
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    check({tag, " R3 result"}, result_o, model(a, b));
    check({tag, " R5 busy cycles"}, 32'(n), 32'(exp_cycles(b)));
    check({tag, " R6 busy low with done"}, 32'(busy_o), 32'd0);
  endtask

  task automatic single(input string tag, input logic [31:0] a, input logic [31:0] b);
    issue(a, b);
    check({tag, " R2 busy after accept"}, 32'(busy_o), 32'd1);
    finish_op(tag, a, b, 1'b0);
    @(negedge clk);
    check({tag, " R6 done one cycle"}, 32'(done_o), 32'd0);
    check({tag, " R8 result held"}, result_o, model(a, b));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy_o), 32'd0);
    check("R1 done", 32'(done_o), 32'd0);
    check("R1 result", result_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_boundaries;
    single("R5 zero", 32'h1234_5678, 32'd0);
    single("R5 2047", 32'h0000_0ABC, 32'd2047);
    single("R5 2048", 32'h0000_0ABC, 32'd2048);
    single("R5 2^22-1", 32'h0000_0013, 32'h003F_FFFF);
    single("R5 2^22", 32'h0000_0013, 32'h0040_0000);
    single("R5 max", 32'h0000_0001, 32'hFFFF_FFFF);
  endtask

  task automatic t_patterns;
    single("R3 mixed", 32'h0001_2345, 32'h0000_6789);
    single("R4 overflow", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    single("R4 high wrap", 32'hDEAD_BEEF, 32'hCAFE_F00D);
    single("R3 zero mcand", 32'd0, 32'h8000_0001);
  endtask

  task automatic t_ignore_busy;
    issue(32'h0BAD_F00D, 32'h8765_4321);
    finish_op("R7 start while busy", 32'h0BAD_F00D, 32'h8765_4321, 1'b1);
    @(negedge clk);
    check("R7 no second op busy", 32'(busy_o), 32'd0);
    check("R7 no second op done", 32'(done_o), 32'd0);
    check("R7 result kept", result_o, model(32'h0BAD_F00D, 32'h8765_4321));
  endtask

  task automatic t_back_to_back;
    issue(32'h0000_1111, 32'h0000_0222);
    finish_op("R9 first", 32'h0000_1111, 32'h0000_0222, 1'b0);
    issue(32'h0003_0003, 32'h0100_0000);
    check("R9 accepted during done", 32'(busy_o), 32'd1);
    check("R9 done dropped", 32'(done_o), 32'd0);
    finish_op("R9 second", 32'h0003_0003, 32'h0100_0000, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_boundaries();
    t_patterns();
    t_ignore_busy();
    t_back_to_back();
    finished = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule